// File: doc/BRIEF.md
# Balanced-Symbol Packet Serialiser

This block turns a short packet held in an external byte buffer into the synchronous bit stream that feeds a radio transmitter. One bit period is a fixed number of system clocks (`CLK_DIV`). A `start` strobe latches the packet length, the preamble cycle count and the wake-up unit count. The block then raises the transmit enable and sends the frame in this order:

- an optional extended preamble, made of wake-up units, each a block of alternating bits closed by a hold code;
- the normal alternating preamble;
- an eight-bit frame sync word;
- every packet byte as a twelve-bit DC-balanced symbol;
- the additive checksum, coded the same way.

The symbol alphabet is not stored as constants. After reset the block fills its own table by walking all twelve-bit words in ascending order and keeping the first 256 that qualify. Byte value `v` is sent as entry `v` of that table. Buffer bytes are fetched through a read port with one cycle of latency while the previous symbol is still going out. One `done` pulse marks the end of a frame.

Top module: `pkt_symbol_tx`

## Requirements
- R1: While and after reset, `tx_en`, `tx_bit`, `bit_stb` and `done` are 0 until a frame is started.
- R2: While `tx_en` is high, consecutive `bit_stb` pulses are exactly `CLK_DIV` clocks apart, `bit_stb` pulses only while `tx_en` is high, and `tx_bit` changes only in a cycle where `bit_stb` is high.
- R3: `tx_bit` is 0 in every cycle where `tx_en` is 0.
- R4: The normal preamble is `pre_cycles` repetitions of bit 0 followed by bit 1; a count of 0 sends no normal preamble. The first bit of a frame appears together with the rise of `tx_en` and a `bit_stb` pulse.
- R5: The normal preamble is followed by the sync word 1,1,1,0,0,1,0,0 (a 7-bit Barker pattern plus a 0 balancing bit, first bit first).
- R6: When `wake_units` is nonzero, the frame starts with that many units, each made of `HOLD_PERIOD` repetitions of 0,1 followed by the hold code 0,0,0,1,1,0,1,1 (the bitwise inverse of the sync word); the normal preamble follows the last unit.
- R7: Bytes at buffer addresses 0 to `pkt_len`-1 are sent in address order. Each byte value v is sent as the v-th (from 0) smallest 12-bit word that has exactly six ones and no run of five or more equal bits, most significant bit first.
- R8: The last symbol is the code of (sum of all sent bytes) mod 256. With `pkt_len` = 0 only the sync word and the code of 0 follow the preamble.
- R9: `done` is a single-cycle pulse that appears exactly `CLK_DIV` clocks after the last checksum bit appeared. In that cycle `tx_en` has just fallen to 0.
- R10: `start` has no effect while a frame is being sent, and none during the table fill after reset (fewer than 4096 clocks).
- R11: `pkt_len`, `pre_cycles` and `wake_units` are sampled only in the cycle a frame starts; later changes do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted only when idle and the table is filled) |
| pkt_len | input | $clog2(MAX_LEN+1) | Number of packet bytes |
| pre_cycles | input | 8 | Normal preamble cycle count |
| wake_units | input | 8 | Extended preamble unit count, 0 for none |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_data | input | 8 | Buffer byte, valid one clock after `rd_addr` |
| tx_en | output | 1 | Transmitter enable |
| tx_bit | output | 1 | Serial data |
| bit_stb | output | 1 | One-clock pulse in the cycle a new bit appears |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The bench builds the block with `CLK_DIV` = 3, `HOLD_PERIOD` = 4 and `MAX_LEN` = 8. These short bit periods and wake-up units keep each frame to a few hundred clocks. That makes it cheap to push all 256 byte values through the encoder in 32 full frames, and to compare every symbol against a table the bench derives by its own run counting. The eight-byte buffer lets the bench sweep every length from 0 to the maximum. It also covers a checksum that wraps, zero and nonzero preamble counts, frames of one and two wake-up units, and inputs that are disturbed while a frame is in flight.

// File: rtl/pkt_tx_pkg.sv
`timescale 1ns/1ps
package pkt_tx_pkg;

    localparam int SYM_W      = 12;
    localparam int SYM_COUNT  = 256;
    localparam int RUN_LIMIT  = 4;
    localparam int BYTE_W     = 8;
    localparam int UNIT_CNT_W = 4;

    // sync word: Barker-7 followed by a balancing zero
    localparam logic [7:0] SYNC_WORD = 8'b1110_0100;
    localparam logic [7:0] HOLD_WORD = ~SYNC_WORD;

    typedef enum logic [2:0] {
        K_IDLE,
        K_WPRE,
        K_HOLD,
        K_PRE,
        K_SYNC,
        K_DATA,
        K_CSUM
    } unit_kind_e;

    typedef struct packed {
        unit_kind_e              kind;
        logic [SYM_W-1:0]        sh;
        logic [UNIT_CNT_W-1:0]   nleft;
    } tx_unit_t;

    // word qualifies as a symbol: balanced and no run longer than RUN_LIMIT
    function automatic logic sym_ok(input logic [SYM_W-1:0] w);
        logic ok;
        ok = ($countones(w) == SYM_W / 2);
        for (int i = 0; i <= SYM_W - RUN_LIMIT - 1; i++) begin
            if ((&w[i +: RUN_LIMIT + 1]) || !(|w[i +: RUN_LIMIT + 1]))
                ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/pkt_bit_timer.sv
`timescale 1ns/1ps
module pkt_bit_timer #(
    parameter int CLK_DIV = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/pkt_sym_rom.sv
`timescale 1ns/1ps
module pkt_sym_rom
    import pkt_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] idx,
    output logic [SYM_W-1:0]  sym,
    output logic              ready
);
    localparam int FILL_W = $clog2(SYM_COUNT) + 1;

    logic [SYM_W-1:0]  tbl [SYM_COUNT];
    logic [SYM_W-1:0]  cand_q;
    logic [FILL_W-1:0] fill_q;
    logic              hit;

    assign ready = fill_q[FILL_W-1];
    assign hit   = !ready && sym_ok(cand_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
            fill_q <= '0;
        end else if (!ready) begin
            cand_q <= cand_q + SYM_W'(1);
            if (hit)
                fill_q <= fill_q + FILL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (hit)
            tbl[fill_q[FILL_W-2:0]] <= cand_q;
    end

    assign sym = tbl[idx];

endmodule

// File: rtl/pkt_frame_seq.sv
`timescale 1ns/1ps
module pkt_frame_seq
    import pkt_tx_pkg::*;
#(
    parameter int HOLD_PERIOD = 256,
    parameter int LEN_W       = 5,
    parameter int ADDR_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [7:0]        pre_cycles,
    input  logic [7:0]        wake_units,
    input  logic              tick,
    input  logic              rom_ready,
    input  logic [SYM_W-1:0]  rom_sym,
    output logic [BYTE_W-1:0] rom_idx,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              accept,
    output logic              tx_en,
    output logic              tx_bit,
    output logic              bit_stb,
    output logic              done
);
    localparam int CYC_W = ($clog2(HOLD_PERIOD) > 8) ? $clog2(HOLD_PERIOD) : 8;
    localparam logic [SYM_W-1:0] PRE_PAT  = {2'b01, {(SYM_W-2){1'b0}}};
    localparam logic [SYM_W-1:0] SYNC_PAT = {SYNC_WORD, {(SYM_W-8){1'b0}}};
    localparam logic [SYM_W-1:0] HOLD_PAT = {HOLD_WORD, {(SYM_W-8){1'b0}}};

    tx_unit_t          cur_q, ent;
    unit_kind_e        ent_kind;
    logic              ent_valid, finish, from_idle;
    logic [CYC_W-1:0]  cyc_q;
    logic [7:0]        pre_q, wake_q, pre_src;
    logic [LEN_W-1:0]  bytes_q;
    logic [BYTE_W-1:0] sum_q;
    logic [ADDR_W-1:0] addr_q;
    logic              tx_en_q, tx_bit_q, stb_q, done_q;

    assign from_idle = (cur_q.kind == K_IDLE);
    assign pre_src   = from_idle ? pre_cycles : pre_q;

    // decide which unit follows the one now ending
    always_comb begin
        ent_valid = 1'b0;
        ent_kind  = K_IDLE;
        finish    = 1'b0;
        if (from_idle) begin
            if (start && rom_ready) begin
                ent_valid = 1'b1;
                ent_kind  = (wake_units != 8'd0) ? K_WPRE :
                            ((pre_cycles != 8'd0) ? K_PRE : K_SYNC);
            end
        end else if (tick && cur_q.nleft == UNIT_CNT_W'(1)) begin
            ent_valid = 1'b1;
            case (cur_q.kind)
                K_WPRE:  ent_kind = (cyc_q != '0) ? K_WPRE : K_HOLD;
                K_HOLD:  ent_kind = (wake_q != 8'd0) ? K_WPRE :
                                    ((pre_q != 8'd0) ? K_PRE : K_SYNC);
                K_PRE:   ent_kind = (cyc_q != '0) ? K_PRE : K_SYNC;
                K_SYNC:  ent_kind = (bytes_q != '0) ? K_DATA : K_CSUM;
                K_DATA:  ent_kind = (bytes_q != '0) ? K_DATA : K_CSUM;
                default: begin
                    ent_valid = 1'b0;
                    finish    = 1'b1;
                end
            endcase
        end
    end

    assign rom_idx = (ent_kind == K_CSUM) ? sum_q : rd_data;

    // bit pattern of the unit being entered
    always_comb begin
        ent.kind = ent_kind;
        case (ent_kind)
            K_WPRE, K_PRE: begin ent.sh = PRE_PAT;  ent.nleft = UNIT_CNT_W'(2);     end
            K_SYNC:        begin ent.sh = SYNC_PAT; ent.nleft = UNIT_CNT_W'(8);     end
            K_HOLD:        begin ent.sh = HOLD_PAT; ent.nleft = UNIT_CNT_W'(8);     end
            K_DATA, K_CSUM:begin ent.sh = rom_sym;  ent.nleft = UNIT_CNT_W'(SYM_W); end
            default:       begin ent.sh = '0;       ent.nleft = '0;                 end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '{kind: K_IDLE, sh: '0, nleft: '0};
            cyc_q    <= '0;
            pre_q    <= '0;
            wake_q   <= '0;
            bytes_q  <= '0;
            sum_q    <= '0;
            addr_q   <= '0;
            tx_en_q  <= 1'b0;
            tx_bit_q <= 1'b0;
            stb_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            stb_q  <= 1'b0;
            done_q <= 1'b0;
            if (ent_valid) begin
                cur_q    <= ent;
                tx_en_q  <= 1'b1;
                tx_bit_q <= ent.sh[SYM_W-1];
                stb_q    <= 1'b1;
                if (from_idle) begin
                    pre_q   <= pre_cycles;
                    wake_q  <= wake_units;
                    bytes_q <= pkt_len;
                    sum_q   <= '0;
                    addr_q  <= '0;
                end
                case (ent_kind)
                    K_WPRE: cyc_q <= (cur_q.kind == K_WPRE) ? cyc_q - CYC_W'(1)
                                                             : CYC_W'(HOLD_PERIOD - 1);
                    K_PRE:  cyc_q <= (cur_q.kind == K_PRE)  ? cyc_q - CYC_W'(1)
                                                             : CYC_W'(pre_src) - CYC_W'(1);
                    K_HOLD: wake_q <= wake_q - 8'd1;
                    K_DATA: begin
                        bytes_q <= bytes_q - LEN_W'(1);
                        sum_q   <= sum_q + rd_data;
                        addr_q  <= addr_q + ADDR_W'(1);
                    end
                    default: ;
                endcase
            end else if (finish) begin
                cur_q.kind <= K_IDLE;
                tx_en_q    <= 1'b0;
                tx_bit_q   <= 1'b0;
                done_q     <= 1'b1;
            end else if (tick && !from_idle) begin
                cur_q.sh    <= cur_q.sh << 1;
                cur_q.nleft <= cur_q.nleft - UNIT_CNT_W'(1);
                tx_bit_q    <= cur_q.sh[SYM_W-2];
                stb_q       <= 1'b1;
            end
        end
    end

    assign accept  = from_idle && ent_valid;
    assign rd_addr = addr_q;
    assign tx_en   = tx_en_q;
    assign tx_bit  = tx_bit_q;
    assign bit_stb = stb_q;
    assign done    = done_q;

endmodule

// File: rtl/pkt_symbol_tx.sv
`timescale 1ns/1ps
module pkt_symbol_tx
    import pkt_tx_pkg::*;
#(
    parameter  int CLK_DIV     = 5000,
    parameter  int MAX_LEN     = 27,
    parameter  int HOLD_PERIOD = 256,
    localparam int LEN_W       = $clog2(MAX_LEN + 1),
    localparam int ADDR_W      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [7:0]        pre_cycles,
    input  logic [7:0]        wake_units,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              tx_en,
    output logic              tx_bit,
    output logic              bit_stb,
    output logic              done
);
    logic              tick, accept, rom_ready;
    logic [SYM_W-1:0]  rom_sym;
    logic [BYTE_W-1:0] rom_idx;

    pkt_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (tx_en),
        .tick  (tick)
    );

    pkt_sym_rom u_rom (
        .clk   (clk),
        .rst   (rst),
        .idx   (rom_idx),
        .sym   (rom_sym),
        .ready (rom_ready)
    );

    pkt_frame_seq #(
        .HOLD_PERIOD (HOLD_PERIOD),
        .LEN_W       (LEN_W),
        .ADDR_W      (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pkt_len    (pkt_len),
        .pre_cycles (pre_cycles),
        .wake_units (wake_units),
        .tick       (tick),
        .rom_ready  (rom_ready),
        .rom_sym    (rom_sym),
        .rom_idx    (rom_idx),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .accept     (accept),
        .tx_en      (tx_en),
        .tx_bit     (tx_bit),
        .bit_stb    (bit_stb),
        .done       (done)
    );

endmodule

// File: rtl/pkt_symbol_tx_chk.sv
`timescale 1ns/1ps
module pkt_symbol_tx_chk #(
    parameter int CLK_DIV = 5000
) (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_bit,
    input logic bit_stb,
    input logic done
);
    localparam int GAP_W = $clog2(CLK_DIV + 2) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (bit_stb)
                gap_q <= GAP_W'(1);
            else if (gap_q != '1)
                gap_q <= gap_q + GAP_W'(1);
            seen_q <= tx_en && (seen_q || bit_stb);
        end
    end

    // R3
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !tx_bit);

    // R2
    hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !bit_stb) |-> $stable(tx_bit));

    // R2
    stb_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && seen_q) |-> (gap_q == GAP_W'(CLK_DIV)));

    // R2
    stb_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> tx_en);

    // R4
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> bit_stb);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_edge_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tx_en && $past(tx_en)));

endmodule

bind pkt_symbol_tx pkt_symbol_tx_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .tx_bit  (tx_bit),
    .bit_stb (bit_stb),
    .done    (done)
);

// File: tb/pkt_symbol_tx_bench.sv
`timescale 1ns/1ps
module pkt_symbol_tx_bench;
    localparam int CLK_DIV = 3;
    localparam int MAX_LEN = 8;
    localparam int HOLD    = 4;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int ADDR_W  = $clog2(MAX_LEN);
    localparam int NBUF    = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic [7:0] pre_cycles = '0;
    logic [7:0] wake_units = '0;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0] rd_data;
    logic tx_en, tx_bit, bit_stb, done;

    logic [7:0]  mem [MAX_LEN];
    logic [11:0] ref_sym [256];
    logic        exp_bits [NBUF];
    logic        cap_bits [NBUF];
    int nexp, ncap, gap, gap_bad, low_bad;
    bit gap_seen;
    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) rd_data <= mem[rd_addr];

    pkt_symbol_tx #(
        .CLK_DIV(CLK_DIV), .MAX_LEN(MAX_LEN), .HOLD_PERIOD(HOLD)
    ) u_pkt_symbol_tx (
        .clk(clk), .rst(rst), .start(start), .pkt_len(pkt_len),
        .pre_cycles(pre_cycles), .wake_units(wake_units),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_en(tx_en), .tx_bit(tx_bit), .bit_stb(bit_stb), .done(done)
    );

    // capture serial stream and watch strobe spacing away from the edge
    always @(negedge clk) begin
        if (!tx_en && tx_bit) low_bad++;
        if (bit_stb) begin
            if (ncap < NBUF) cap_bits[ncap] = tx_bit;
            ncap++;
            if (gap_seen && gap != CLK_DIV) gap_bad++;
            gap_seen = 1'b1;
            gap = 1;
        end else begin
            gap++;
        end
        if (!tx_en) gap_seen = 1'b0;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic b);
        if (nexp < NBUF) exp_bits[nexp] = b;
        nexp++;
    endtask

    task automatic push_word(input logic [11:0] w, input int n);
        for (int k = n - 1; k >= 0; k--) push(w[k]);
    endtask

    task automatic build_exp(input int len, input int pre, input int wake);
        int s;
        nexp = 0;
        s = 0;
        for (int u = 0; u < wake; u++) begin
            for (int c = 0; c < HOLD; c++) begin push(1'b0); push(1'b1); end
            push_word(12'b0001_1011, 8);
        end
        for (int c = 0; c < pre; c++) begin push(1'b0); push(1'b1); end
        push_word(12'b1110_0100, 8);
        for (int i = 0; i < len; i++) begin
            push_word(ref_sym[mem[i]], 12);
            s = (s + mem[i]) % 256;
        end
        push_word(ref_sym[s], 12);
    endtask

    task automatic send(input int len, input int pre, input int wake,
                        input bit perturb, input string tag);
        int k, expk, bad_at;
        build_exp(len, pre, wake);
        ncap = 0; gap_bad = 0; low_bad = 0;
        @(negedge clk);
        start = 1'b1;
        pkt_len = LEN_W'(len);
        pre_cycles = 8'(pre);
        wake_units = 8'(wake);
        @(negedge clk);
        start = 1'b0;
        k = 1;
        if (perturb) begin
            pkt_len = LEN_W'(MAX_LEN);
            pre_cycles = 8'd9;
            wake_units = 8'd3;
        end
        while (!done && k < 20000) begin
            start = perturb && (k == 10 || k == 40);
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        expk = nexp * CLK_DIV + 1;
        chk(done && k == expk && !tx_en, "R9", "done cycle", k, expk);
        bad_at = -1;
        if (ncap == nexp) begin
            for (int i = 0; i < nexp; i++)
                if (bad_at < 0 && cap_bits[i] !== exp_bits[i]) bad_at = i;
        end
        chk(ncap == nexp, tag, "bit count", ncap, nexp);
        if (bad_at >= 0)
            chk(1'b0, tag, $sformatf("bit %0d value", bad_at),
                int'(cap_bits[bad_at]), int'(exp_bits[bad_at]));
        else
            chk(1'b1, tag, "bit values", 0, 0);
        chk(gap_bad == 0, "R2", "strobe spacing errors", gap_bad, 0);
        chk(low_bad == 0, "R3", "data high while disabled", low_bad, 0);
        @(negedge clk);
        chk(!done && !tx_en, "R9", "done width", int'(done), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n, ones, run, maxrun, seen_en;
        // independent symbol table: ascending scan with explicit run counting
        n = 0;
        for (int w = 0; w < 4096; w++) begin
            ones = 0; run = 0; maxrun = 0;
            for (int b = 0; b < 12; b++) begin
                ones += (w >> b) & 1;
                if (b > 0 && (((w >> b) & 1) == ((w >> (b - 1)) & 1))) run++;
                else run = 1;
                if (run > maxrun) maxrun = run;
            end
            if (ones == 6 && maxrun <= 4 && n < 256) begin
                ref_sym[n] = 12'(w);
                n++;
            end
        end
        for (int i = 0; i < MAX_LEN; i++) mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!tx_en && !tx_bit && !bit_stb && !done, "R1", "outputs in reset",
            int'({tx_en, tx_bit, bit_stb, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_en && !tx_bit && !bit_stb && !done, "R1", "outputs after reset",
            int'({tx_en, tx_bit, bit_stb, done}), 0);
        // R10: start during table fill is ignored
        start = 1'b1; pkt_len = 4'd2; pre_cycles = 8'd1;
        @(negedge clk);
        start = 1'b0;
        seen_en = 0;
        for (int c = 0; c < 40; c++) begin
            if (tx_en || done) seen_en++;
            @(negedge clk);
        end
        chk(seen_en == 0, "R10", "activity after start during fill", seen_en, 0);
        repeat (4300) @(negedge clk);

        // R7: all 256 byte values through the encoder
        for (int p = 0; p < 32; p++) begin
            for (int i = 0; i < MAX_LEN; i++) mem[i] = 8'(p * 8 + i);
            send(MAX_LEN, 1, 0, 1'b0, "R7");
        end
        // R8: every length including zero
        for (int len = 0; len <= MAX_LEN; len++) begin
            for (int i = 0; i < MAX_LEN; i++) mem[i] = 8'((i * 37 + len * 11 + 5) % 256);
            send(len, 2, 0, 1'b0, "R8");
        end
        // R8: checksum wraps
        for (int i = 0; i < MAX_LEN; i++) mem[i] = 8'hFF;
        send(MAX_LEN, 1, 0, 1'b0, "R8");
        // R4 / R5: preamble counts
        for (int i = 0; i < MAX_LEN; i++) mem[i] = 8'(i * 19 + 3);
        send(3, 0, 0, 1'b0, "R4");
        send(3, 5, 0, 1'b0, "R4");
        send(1, 1, 0, 1'b0, "R5");
        // R6: extended preamble
        send(2, 1, 1, 1'b0, "R6");
        send(1, 0, 2, 1'b0, "R6");
        // R11 / R10: inputs disturbed and start pulsed mid-frame
        send(5, 3, 1, 1'b1, "R11");
        send(4, 2, 0, 1'b1, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule